// File: doc/BRIEF.md
# Multi-Polynomial Serial CRC Encoder and Checker

This block runs a cyclic redundancy check one bit per clock through a single shift register whose feedback taps are picked at run time from five generator polynomials, of degrees 3, 8, 16, 32 and 40. In encode mode the block takes a message most-significant bit first. It then drives the remainder of the message times x^d modulo g(x) onto a serial output, d bits long, so that the parity directly follows the data. In check mode it takes a whole received word, data followed by parity, and reports whether the final remainder is zero.

Framing uses a valid/ready bit handshake with start and last flags. The start beat is the first bit of a frame. It clears the register and samples the mode and polynomial for the rest of the frame. The last beat ends the data. All arithmetic is over GF(2).

Top module: `crc_serial_engine`

## Requirements
- R1: `polySel` picks the generator: 0 = x^16+x^12+x^5+1; 1 = the 32-bit generator with terms 32,26,23,22,16,12,11,10,8,7,5,4,2,1,0; 2 = x^3+x+1; 3 = x^8+x^4+x^3+x^2+1; 4 = x^40+x^26+x^23+x^17+x^3+1. Codes 5 to 7 act as code 0. Register bits above the selected degree stay zero.
- R2: In encode mode (`modeCheck`=0), exactly d parity bits appear on `parOut` with `parValid` high, one per cycle and highest degree first. They start in the cycle after the last data bit is accepted and equal the remainder of m(x)·x^d divided by g(x).
- R3: While parity is being shifted out, `inReady` is low and offered bits are not consumed.
- R4: `done` is a one-cycle pulse. It comes in the cycle after the final parity bit in encode mode, or in the cycle after the last accepted bit in check mode.
- R5: In check mode (`modeCheck`=1), `checkPass` pulses with `done` when the remainder of the received word is zero, and `checkFail` pulses with `done` otherwise. The two are never high together.
- R6: An accepted start beat clears the remainder before it uses its own bit, even in the middle of a frame, so earlier bits have no effect.
- R7: Cycles with `inValid` low change nothing, whatever the other inputs carry.
- R8: Accepted beats without `inStart` while no frame is open are ignored.
- R9: `modeCheck` and `polySel` are sampled only on the start beat. Changing them during a frame has no effect.
- R10: A beat carrying both `inStart` and `inLast` is a complete one-bit frame.
- R11: After reset, `inReady` is high and `parValid`, `done`, `checkPass` and `checkFail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input bit offered |
| inReady | output | 1 | Block can take a bit |
| inBit | input | 1 | Serial data bit |
| inStart | input | 1 | Beat is the first bit of a frame |
| inLast | input | 1 | Beat is the last bit of a frame |
| modeCheck | input | 1 | 0 encode, 1 check; sampled on start |
| polySel | input | 3 | Generator code; sampled on start |
| parOut | output | 1 | Serial parity bit |
| parValid | output | 1 | parOut carries a parity bit |
| done | output | 1 | End-of-frame pulse |
| checkPass | output | 1 | Zero remainder, with done |
| checkFail | output | 1 | Nonzero remainder, with done |

## Verification
The assertions check on every cycle that `done` lasts one cycle, that a verdict appears only together with `done` and never as both pass and fail, that a parity burst ends in `done`, that no bit is taken during a burst, and that register bits above the selected degree stay clear. The directed scenarios are the only check that the parity values and the pass/fail verdicts are correct for each polynomial. A bench model based on long division supplies the expected values. The scenarios also cover gaps, stray idle beats, a restart in mid-frame, select changes during a frame and one-bit frames.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int MAX_DEG  = 40;
  localparam int SEL_W    = 3;
  localparam int NUM_POLY = 5;
  localparam int DEG_W    = $clog2(MAX_DEG + 1);

  typedef logic [MAX_DEG-1:0] remT;
  typedef logic [DEG_W-1:0]   degT;
  typedef logic [SEL_W-1:0]   selT;

  // Strobes from the frame control to the shift datapath
  typedef struct packed {
    logic startStep;  // accepted first bit: clear, latch select, step
    logic dataStep;   // accepted later data bit: step
    logic parShift;   // shift one parity bit out
  } dpCtrlT;

  // Feedback taps below the leading term; codes beyond the table fall back to 0
  function automatic remT tapsOf(selT s);
    case (s)
      selT'(1): tapsOf = remT'(40'h00_04C1_1DB7);
      selT'(2): tapsOf = remT'(40'h00_0000_0003);
      selT'(3): tapsOf = remT'(40'h00_0000_001D);
      selT'(4): tapsOf = remT'(40'h00_0482_0009);
      default:  tapsOf = remT'(40'h00_0000_1021);
    endcase
  endfunction

  function automatic degT degOf(selT s);
    case (s)
      selT'(1): degOf = degT'(32);
      selT'(2): degOf = degT'(3);
      selT'(3): degOf = degT'(8);
      selT'(4): degOf = degT'(40);
      default:  degOf = degT'(16);
    endcase
  endfunction

  function automatic remT maskOf(degT d);
    remT m;
    for (int i = 0; i < MAX_DEG; i++) m[i] = (i < int'(d));
    return m;
  endfunction
endpackage

// File: rtl/crc_lfsr_path.sv
module crc_lfsr_path
  import crc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpCtrlT ctl,
  input  logic   inBit,
  input  selT    polySelIn,
  output logic   parBit,
  output degT    stepDeg,
  output logic   stepZero
);
  selT  selQ;
  remT  remQ;
  selT  effSel;
  remT  effRem, effTaps, effMask, heldMask;
  remT  stepRem, shiftRem;
  degT  effDeg, heldDeg;
  degT  msbIdx, heldIdx;
  logic fb;

  // On a start beat the fresh select and a zero register take effect at once
  always_comb begin
    effSel   = ctl.startStep ? polySelIn : selQ;
    effRem   = ctl.startStep ? '0 : remQ;
    effTaps  = tapsOf(effSel);
    effDeg   = degOf(effSel);
    effMask  = maskOf(effDeg);
    msbIdx   = effDeg - degT'(1);
    fb       = inBit ^ effRem[msbIdx];
    heldDeg  = degOf(selQ);
    heldMask = maskOf(heldDeg);
    heldIdx  = heldDeg - degT'(1);
  end

  for (genvar g = 0; g < MAX_DEG; g++) begin : gBit
    if (g == 0) begin : gLow
      assign stepRem[g]  = effMask[g] & fb & effTaps[g];
      assign shiftRem[g] = 1'b0;
    end else begin : gHigh
      assign stepRem[g]  = effMask[g] & (effRem[g-1] ^ (fb & effTaps[g]));
      assign shiftRem[g] = heldMask[g] & remQ[g-1];
    end
  end

  assign stepDeg  = effDeg;
  assign stepZero = (stepRem == '0);
  assign parBit   = remQ[heldIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      remQ <= '0;
    end else begin
      if (ctl.startStep) selQ <= polySelIn;
      if (ctl.startStep || ctl.dataStep) remQ <= stepRem;
      else if (ctl.parShift)             remQ <= shiftRem;
    end
  end

  // R1: nothing leaks above the degree of the latched generator
  p_upper_bits_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    (remQ & ~maskOf(degOf(selQ))) == '0);

  // R3: the control never steps data while a parity burst is running
  p_no_step_in_burst_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.parShift |-> !(ctl.dataStep || ctl.startStep));
endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inStart,
  input  logic   inLast,
  input  logic   modeCheck,
  input  degT    stepDeg,
  input  logic   stepZero,
  output logic   inReady,
  output dpCtrlT ctl,
  output logic   parValid,
  output logic   done,
  output logic   checkPass,
  output logic   checkFail
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PARITY} stateT;

  stateT stateQ;
  logic  modeQ, doneQ, passQ, failQ;
  degT   cntQ;
  logic  accept, effMode, frameEnd;

  always_comb begin
    inReady       = (stateQ != ST_PARITY);
    accept        = inValid && inReady;
    ctl.startStep = accept && inStart;
    ctl.dataStep  = accept && !inStart && (stateQ == ST_DATA);
    ctl.parShift  = (stateQ == ST_PARITY);
    effMode       = inStart ? modeCheck : modeQ;
    frameEnd      = (ctl.startStep || ctl.dataStep) && inLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      modeQ  <= 1'b0;
      cntQ   <= '0;
      doneQ  <= 1'b0;
      passQ  <= 1'b0;
      failQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      passQ <= 1'b0;
      failQ <= 1'b0;
      if (ctl.startStep) modeQ <= modeCheck;
      if (frameEnd) begin
        if (effMode) begin
          stateQ <= ST_IDLE;
          doneQ  <= 1'b1;
          passQ  <= stepZero;
          failQ  <= !stepZero;
        end else begin
          stateQ <= ST_PARITY;
          cntQ   <= stepDeg;
        end
      end else if (ctl.startStep) begin
        stateQ <= ST_DATA;
      end else if (stateQ == ST_PARITY) begin
        cntQ <= cntQ - degT'(1);
        if (cntQ == degT'(1)) begin
          stateQ <= ST_IDLE;
          doneQ  <= 1'b1;
        end
      end
    end
  end

  assign parValid  = (stateQ == ST_PARITY);
  assign done      = doneQ;
  assign checkPass = passQ;
  assign checkFail = failQ;

  // R4: end-of-frame strobe lasts a single cycle
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: a parity burst is always closed by the done pulse
  p_burst_ends_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parValid) |-> done);

  // R5: verdicts are exclusive and ride on done
  p_verdict_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(checkPass && checkFail));
  p_verdict_with_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (checkPass || checkFail) |-> done);
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inBit,
  input  logic             inStart,
  input  logic             inLast,
  input  logic             modeCheck,
  input  logic [SEL_W-1:0] polySel,
  output logic             parOut,
  output logic             parValid,
  output logic             done,
  output logic             checkPass,
  output logic             checkFail
);
  dpCtrlT ctl;
  degT    stepDeg;
  logic   stepZero;

  crc_frame_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inStart   (inStart),
    .inLast    (inLast),
    .modeCheck (modeCheck),
    .stepDeg   (stepDeg),
    .stepZero  (stepZero),
    .inReady   (inReady),
    .ctl       (ctl),
    .parValid  (parValid),
    .done      (done),
    .checkPass (checkPass),
    .checkFail (checkFail)
  );

  crc_lfsr_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inBit     (inBit),
    .polySelIn (polySel),
    .parBit    (parOut),
    .stepDeg   (stepDeg),
    .stepZero  (stepZero)
  );
endmodule

// File: tb/sim_crc_serial_engine.sv
module sim_crc_serial_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inBit = 1'b0, inStart = 1'b0, inLast = 1'b0, modeCheck = 1'b0;
  logic [2:0] polySel = '0;
  logic inReady, parOut, parValid, done, checkPass, checkFail;

  int nChecks = 0;
  int nFails  = 0;
  bit msg [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_serial_engine u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inBit(inBit),
    .inStart(inStart), .inLast(inLast), .modeCheck(modeCheck), .polySel(polySel),
    .parOut(parOut), .parValid(parValid), .done(done),
    .checkPass(checkPass), .checkFail(checkFail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Generator as full coefficient vector, built from its exponents
  function automatic logic [40:0] polyFull(input int sel);
    logic [40:0] p = '0;
    case (sel)
      1: begin p[32]=1; p[26]=1; p[23]=1; p[22]=1; p[16]=1; p[12]=1; p[11]=1;
               p[10]=1; p[8]=1; p[7]=1; p[5]=1; p[4]=1; p[2]=1; p[1]=1; p[0]=1; end
      2: begin p[3]=1; p[1]=1; p[0]=1; end
      3: begin p[8]=1; p[4]=1; p[3]=1; p[2]=1; p[0]=1; end
      4: begin p[40]=1; p[26]=1; p[23]=1; p[17]=1; p[3]=1; p[0]=1; end
      default: begin p[16]=1; p[12]=1; p[5]=1; p[0]=1; end
    endcase
    return p;
  endfunction

  function automatic int degree(input int sel);
    case (sel)
      1: return 32;
      2: return 3;
      3: return 8;
      4: return 40;
      default: return 16;
    endcase
  endfunction

  // Long division of msg[0..n-1]*x^d; first bit is the highest degree
  function automatic logic [39:0] refPar(input int sel, input int n);
    bit buffer [0:300];
    logic [40:0] p = polyFull(sel);
    int d = degree(sel);
    logic [39:0] r = '0;
    for (int i = 0; i < n + d; i++) buffer[i] = (i < n) ? msg[i] : 1'b0;
    for (int i = 0; i < n; i++)
      if (buffer[i])
        for (int j = 0; j <= d; j++) buffer[i+j] ^= p[d-j];
    for (int j = 0; j < d; j++) r = {r[38:0], buffer[n+j]};
    return r;
  endfunction

  task automatic fillMsg(input int n, input int seed);
    int s = seed;
    for (int i = 0; i < n; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      msg[i] = s[16];
    end
  endtask

  task automatic beat(input bit v, input bit b, input bit st, input bit ls,
                      input bit md, input logic [2:0] sel);
    @(negedge clk);
    inValid = v; inBit = b; inStart = st; inLast = ls; modeCheck = md; polySel = sel;
  endtask

  // Collect a parity burst; junk bits stay offered to show they are refused
  task automatic collect(output logic [39:0] par, output int nPar,
                         output bit doneSeen, output bit readyLeak);
    par = '0; nPar = 0; doneSeen = 0; readyLeak = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      inValid = 1'b1; inBit = c[0]; inStart = 1'b0; inLast = 1'b0;
      if (parValid) begin
        par = {par[38:0], parOut};
        nPar++;
        if (inReady) readyLeak = 1;
      end
      if (done) begin doneSeen = 1; break; end
    end
    inValid = 1'b0;
  endtask

  task automatic sendFrame(input int n, input bit md, input logic [2:0] sel, input bit gaps);
    for (int i = 0; i < n; i++) begin
      beat(1, msg[i], i == 0, i == n - 1, md, sel);
      if (gaps && i != n - 1) beat(0, ~msg[i], 1, 1, ~md, 3'd2);
    end
  endtask

  task automatic encodeCheck(input int sel, input int n, input bit gaps,
                             input string req, input logic [2:0] selCode);
    logic [39:0] par;
    int nPar, d;
    bit dn, leak;
    d = degree(sel);
    sendFrame(n, 0, selCode, gaps);
    collect(par, nPar, dn, leak);
    chk(nPar == d, req, "parity bit count", nPar, d);
    chk(par == refPar(sel, n), req, "parity value", par, refPar(sel, n));
    chk(dn, "R4", "done after parity", dn, 1);
    chk(!leak, "R3", "inReady low during parity", leak, 0);
  endtask

  task automatic t_reset();
    chk(inReady === 1'b1, "R11", "inReady after reset", inReady, 1);
    chk({parValid, done, checkPass, checkFail} === 4'b0, "R11", "outputs after reset",
        {parValid, done, checkPass, checkFail}, 0);
  endtask

  task automatic t_encode_all();
    for (int s = 0; s < 5; s++) begin
      fillMsg(60 + s * 7, 17 + s);
      encodeCheck(s, 60 + s * 7, 0, "R2", 3'(s));
    end
    fillMsg(40, 5);
    encodeCheck(0, 40, 0, "R1", 3'd6);
  endtask

  task automatic checkWord(input int sel, input int n, input int flip, input string req);
    logic [39:0] r;
    int d;
    d = degree(sel);
    r = refPar(sel, n);
    for (int j = 0; j < d; j++) msg[n+j] = r[d-1-j];
    if (flip >= 0) msg[flip] = ~msg[flip];
    sendFrame(n + d, 1, 3'(sel), 0);
    @(negedge clk);
    inValid = 1'b0;
    chk(done === 1'b1, "R4", "done after check word", done, 1);
    chk(checkPass === (flip < 0), req, "checkPass", checkPass, flip < 0);
    chk(checkFail === (flip >= 0), req, "checkFail", checkFail, flip >= 0);
    @(negedge clk);
    chk(done === 1'b0, "R4", "done single cycle", done, 0);
  endtask

  task automatic t_check_mode();
    for (int s = 0; s < 5; s++) begin
      fillMsg(50, 91 + s);
      checkWord(s, 50, -1, "R5");
      fillMsg(50, 91 + s);
      checkWord(s, 50, 13 + s, "R5");
    end
  endtask

  task automatic t_gaps();
    fillMsg(45, 222);
    encodeCheck(3, 45, 1, "R7", 3'd3);
  endtask

  task automatic t_idle_junk();
    for (int i = 0; i < 6; i++) beat(1, i[0], 0, i == 5, 1, 3'd4);
    @(negedge clk);
    inValid = 1'b0;
    chk(!parValid && !done && inReady, "R8", "idle beats ignored",
        {parValid, done, inReady}, 3'b001);
    fillMsg(30, 333);
    encodeCheck(2, 30, 0, "R8", 3'd2);
  endtask

  task automatic t_restart();
    logic [39:0] par;
    int nPar;
    bit dn, leak;
    fillMsg(20, 444);
    for (int i = 0; i < 20; i++) beat(1, msg[i], i == 0, 0, 0, 3'd1);
    fillMsg(33, 555);
    sendFrame(33, 0, 3'd0, 0);
    collect(par, nPar, dn, leak);
    chk(par == refPar(0, 33) && nPar == 16, "R6", "restart discards earlier bits",
        par, refPar(0, 33));
  endtask

  task automatic t_midframe_select();
    logic [39:0] par;
    int nPar;
    bit dn, leak;
    fillMsg(36, 666);
    for (int i = 0; i < 36; i++) beat(1, msg[i], i == 0, i == 35, i == 0 ? 1'b0 : 1'b1,
                                      i == 0 ? 3'd4 : 3'd2);
    collect(par, nPar, dn, leak);
    chk(nPar == 40, "R9", "degree held from start beat", nPar, 40);
    chk(par == refPar(4, 36), "R9", "parity with held select", par, refPar(4, 36));
  endtask

  task automatic t_single_bit();
    logic [39:0] par;
    int nPar;
    bit dn, leak;
    msg[0] = 1'b1;
    beat(1, 1, 1, 1, 0, 3'd3);
    collect(par, nPar, dn, leak);
    chk(nPar == 8 && par == refPar(3, 1), "R10", "one-bit encode frame", par, refPar(3, 1));
    beat(1, 0, 1, 1, 1, 3'd2);
    @(negedge clk);
    inValid = 1'b0;
    chk(done && checkPass && !checkFail, "R10", "one-bit zero word passes",
        {done, checkPass, checkFail}, 3'b110);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_encode_all();
    t_check_mode();
    t_gaps();
    t_idle_junk();
    t_restart();
    t_midframe_select();
    t_single_bit();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule